// File: doc/BRIEF.md
# Quadrature Step Generator

This block turns a stream of 14-bit absolute angle words into the incremental outputs of an optical encoder. It produces two quadrature phases, A and B, and an index line. Each new angle goes through a direction-aware hysteresis filter. The filtered angle is then scaled to one of eleven step counts per revolution, eight decimal and three binary. The scaled value becomes the target position.

An internal position register follows the target one quadrature step at a time. Steps are spaced at least `STEP_GAP` clocks apart, and the position always takes the shorter way round the circle. A large jump in angle is therefore replayed as a burst of individual steps, and none is skipped. A downstream counter decoding A/B can keep count without ever seeing an illegal transition.

A ready input and a fault input force all three outputs high. The first gives a defined state during startup and the second a safe state during an error.

Top module: `quad_step_gen`

## Requirements
- R1: While `ready_i` is low, all three outputs are 1, every valid angle passes the hysteresis filter unchanged, and the position is loaded directly from the target. When `ready_i` rises, the outputs show the target position at once, with no replayed steps.
- R2: From the clock after `fault_i` is sampled high, A, B and the index are all held at 1. The position keeps following the target during the fault, so the clock after release shows the current target.
- R3: With `bin_mode_i`=0, resolution codes 0 to 7 select 4000, 2000, 1600, 1200, 800, 400, 200 and 100 steps per revolution. One full turn of the angle gives exactly that many net output steps.
- R4: With `bin_mode_i`=1, code 0 selects 4096 steps, code 1 selects 2048, and code 2 and every higher code select 1024.
- R5: The target is floor(angle × steps / 16384). Once stepping has stopped, the output position equals the target.
- R6: Position p drives (A,B) from p mod 4 as 0→(0,0), 1→(1,0), 2→(1,1), 3→(0,1). An increasing angle therefore makes A lead B. With `dir_inv_i`=1 the A and B lines are swapped. Successive outputs differ by exactly one phase.
- R7: The index output is 1 exactly while the position is 0, and at that point A=B=0. It rises once per revolution.
- R8: The hysteresis band is (3 − `hyst_i`) × 8 angle LSBs: code 0 gives 24 and code 3 gives 0. The movement of a new angle is the signed 14-bit difference from the held angle. A movement in the same direction as the last accepted one is always accepted. A reversal is accepted only when its size exceeds the band.
- R9: Two output steps are never closer than `STEP_GAP` clocks. The position keeps stepping until it equals the target, so a jump of N steps shows N output steps.
- R10: The stepping direction is set by the forward distance (target − position) mod steps. A distance up to half a revolution steps upward and a larger one steps downward. A downward path passes through 0 and raises the index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| angle_i | input | 14 | Absolute angle word |
| angle_vld_i | input | 1 | Strobe marking a new angle |
| res_sel_i | input | 3 | Resolution code |
| bin_mode_i | input | 1 | 1 selects binary step counts, 0 decimal |
| dir_inv_i | input | 1 | Swaps the A and B lines |
| hyst_i | input | 2 | Hysteresis band code |
| fault_i | input | 1 | Forces the safe output state |
| ready_i | input | 1 | Startup finished |
| out_a | output | 1 | Quadrature phase A |
| out_b | output | 1 | Quadrature phase B |
| out_idx | output | 1 | Index, high at position 0 |

## Verification
The bench builds the block with `STEP_GAP` set to 2 and the angle and position widths left at their defaults. A short gap makes full-revolution sweeps affordable at every resolution: the 16-step burst produced by each 64-LSB angle increment at 4096 steps fits between updates. It also brings within reach jumps of a thousand steps that wrap through zero, and randomized jumps that run the position through long catch-up runs at every step spacing.

// File: rtl/qenc_pkg.sv
package qenc_pkg;

    localparam int ANG_W = 14;
    localparam int POS_W = 13;

    typedef logic [POS_W-1:0] pos_t;

    typedef struct packed {
        logic a;
        logic b;
        logic idx;
    } quad_t;

    typedef enum logic [1:0] {
        MV_HOLD = 2'd0,
        MV_UP   = 2'd1,
        MV_DN   = 2'd2
    } move_e;

    // steps per revolution for a resolution code and mode
    function automatic pos_t steps_per_rev(input logic [2:0] code, input logic bin);
        pos_t n;
        if (bin) begin
            case (code)
                3'd0:    n = pos_t'(4096);
                3'd1:    n = pos_t'(2048);
                default: n = pos_t'(1024);
            endcase
        end else begin
            case (code)
                3'd0:    n = pos_t'(4000);
                3'd1:    n = pos_t'(2000);
                3'd2:    n = pos_t'(1600);
                3'd3:    n = pos_t'(1200);
                3'd4:    n = pos_t'(800);
                3'd5:    n = pos_t'(400);
                3'd6:    n = pos_t'(200);
                default: n = pos_t'(100);
            endcase
        end
        return n;
    endfunction

    // quadrature phase for a position; inv swaps the two lines
    function automatic quad_t phase_out(input pos_t pos, input logic inv);
        quad_t q;
        logic  x;
        logic  y;
        x = pos[0] ^ pos[1];
        y = pos[1];
        q.a   = inv ? y : x;
        q.b   = inv ? x : y;
        q.idx = (pos == '0);
        return q;
    endfunction

endpackage

// File: rtl/qenc_hyst.sv
module qenc_hyst #(
    parameter int ANGLE_W   = 14,
    parameter int HYS_REF_W = 11
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               ready_i,
    input  logic [ANGLE_W-1:0] angle_i,
    input  logic               vld_i,
    input  logic [1:0]         hys_i,
    output logic [ANGLE_W-1:0] held_o
);
    localparam int SHIFT = ANGLE_W - HYS_REF_W;

    logic [ANGLE_W-1:0] held_q;
    logic               up_q;
    logic [ANGLE_W-1:0] delta;
    logic [ANGLE_W-1:0] mag;
    logic [ANGLE_W-1:0] band;
    logic               mv_fwd;
    logic               mv_rev;
    logic               accept;

    always_comb begin
        delta  = angle_i - held_q;
        mv_rev = delta[ANGLE_W-1];
        mv_fwd = !mv_rev && (delta != '0);
        mag    = mv_rev ? (~delta + 1'b1) : delta;
        band   = {{(ANGLE_W-2){1'b0}}, 2'd3 - hys_i} << SHIFT;
        accept = (mv_fwd && up_q) || (mv_rev && !up_q) || (mag > band);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            held_q <= '0;
            up_q   <= 1'b1;
        end else if (vld_i) begin
            if (!ready_i) begin
                held_q <= angle_i;
                up_q   <= 1'b1;
            end else if ((delta != '0) && accept) begin
                held_q <= angle_i;
                up_q   <= mv_fwd;
            end
        end
    end

    assign held_o = held_q;

    // reversal inside the band leaves the held angle untouched
    assert_hold_in_band_R8: assert property (@(posedge clk) disable iff (rst)
        (vld_i && ready_i && (delta != '0) && (delta[ANGLE_W-1] == up_q) && (mag <= band))
        |=> $stable(held_q));

    // before startup completes every valid angle is taken as is
    assert_follow_before_ready_R1: assert property (@(posedge clk) disable iff (rst)
        (vld_i && !ready_i) |=> (held_q == $past(angle_i)));

endmodule

// File: rtl/qenc_scale.sv
module qenc_scale
    import qenc_pkg::*;
#(
    parameter int ANGLE_W = 14,
    parameter int POS_W   = 13
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [ANGLE_W-1:0] held_i,
    input  logic [2:0]         res_i,
    input  logic               bin_i,
    output logic [POS_W-1:0]   target_o,
    output logic [POS_W-1:0]   spr_o
);
    localparam int PROD_W = ANGLE_W + POS_W;

    logic [POS_W-1:0]  spr_c;
    logic [PROD_W-1:0] prod;
    logic [POS_W-1:0]  target_q;
    logic [POS_W-1:0]  spr_q;

    always_comb begin
        spr_c = POS_W'(steps_per_rev(res_i, bin_i));
        prod  = {{POS_W{1'b0}}, held_i} * {{ANGLE_W{1'b0}}, spr_c};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            target_q <= '0;
            spr_q    <= POS_W'(steps_per_rev(3'd0, 1'b1));
        end else begin
            target_q <= prod[ANGLE_W +: POS_W];
            spr_q    <= spr_c;
        end
    end

    assign target_o = target_q;
    assign spr_o    = spr_q;

endmodule

// File: rtl/qenc_stepper.sv
module qenc_stepper
    import qenc_pkg::*;
#(
    parameter int POS_W    = 13,
    parameter int STEP_GAP = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ready_i,
    input  logic [POS_W-1:0] target_i,
    input  logic [POS_W-1:0] spr_i,
    output logic [POS_W-1:0] pos_o
);
    localparam int GAP_W = $clog2(STEP_GAP + 1);

    logic [POS_W-1:0] pos_q;
    logic [POS_W-1:0] spr_prev_q;
    logic [GAP_W-1:0] gap_q;
    logic             snap;
    logic [POS_W:0]   diff;
    logic [POS_W:0]   fwd;
    logic [POS_W:0]   half;
    move_e            move;
    logic [POS_W-1:0] pos_up;
    logic [POS_W-1:0] pos_dn;

    always_comb begin
        snap   = !ready_i || (spr_i != spr_prev_q);
        diff   = {1'b0, target_i} - {1'b0, pos_q};
        fwd    = diff[POS_W] ? (diff + {1'b0, spr_i}) : diff;
        half   = {2'b00, spr_i[POS_W-1:1]};
        if (fwd == '0)
            move = MV_HOLD;
        else if (fwd <= half)
            move = MV_UP;
        else
            move = MV_DN;
        pos_up = (pos_q == spr_i - POS_W'(1)) ? '0 : pos_q + POS_W'(1);
        pos_dn = (pos_q == '0) ? spr_i - POS_W'(1) : pos_q - POS_W'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pos_q      <= '0;
            gap_q      <= '0;
            spr_prev_q <= POS_W'(steps_per_rev(3'd0, 1'b1));
        end else begin
            spr_prev_q <= spr_i;
            if (snap) begin
                pos_q <= target_i;
                gap_q <= '0;
            end else if ((move != MV_HOLD) && (gap_q == '0)) begin
                pos_q <= (move == MV_UP) ? pos_up : pos_dn;
                gap_q <= GAP_W'(STEP_GAP - 1);
            end else if (gap_q != '0) begin
                gap_q <= gap_q - GAP_W'(1);
            end
        end
    end

    assign pos_o = pos_q;

    // observation state for the step-spacing checks
    logic [POS_W-1:0] pos_prev_q;
    logic             snap_prev_q;
    logic [GAP_W-1:0] quiet_q;
    logic             changed;

    assign changed = (pos_q != pos_prev_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            pos_prev_q  <= '0;
            snap_prev_q <= 1'b1;
            quiet_q     <= GAP_W'(STEP_GAP);
        end else begin
            pos_prev_q  <= pos_q;
            snap_prev_q <= snap;
            if (changed)
                quiet_q <= snap_prev_q ? GAP_W'(STEP_GAP) : GAP_W'(1);
            else if (quiet_q != GAP_W'(STEP_GAP))
                quiet_q <= quiet_q + GAP_W'(1);
        end
    end

    assert_step_spacing_R9: assert property (@(posedge clk) disable iff (rst)
        (changed && !snap_prev_q) |-> (quiet_q >= GAP_W'(STEP_GAP)));

    assert_single_step_R6: assert property (@(posedge clk) disable iff (rst)
        (changed && !snap_prev_q) |->
            ((pos_q == pos_prev_q + POS_W'(1)) || (pos_prev_q == pos_q + POS_W'(1)) ||
             ((pos_q == '0) && (pos_prev_q == spr_i - POS_W'(1))) ||
             ((pos_prev_q == '0) && (pos_q == spr_i - POS_W'(1)))));

    assert_pos_in_range_R5: assert property (@(posedge clk) disable iff (rst)
        (spr_i == $past(spr_i)) |-> (pos_q < spr_i));

endmodule

// File: rtl/qenc_outfmt.sv
module qenc_outfmt
    import qenc_pkg::*;
#(
    parameter int POS_W = 13
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ready_i,
    input  logic             fault_i,
    input  logic             inv_i,
    input  logic [POS_W-1:0] pos_i,
    output logic             a_o,
    output logic             b_o,
    output logic             idx_o
);
    quad_t q_q;

    always_ff @(posedge clk) begin
        if (rst)
            q_q <= '1;
        else if (!ready_i || fault_i)
            q_q <= '1;
        else
            q_q <= phase_out(pos_t'(pos_i), inv_i);
    end

    assign a_o   = q_q.a;
    assign b_o   = q_q.b;
    assign idx_o = q_q.idx;

    assert_startup_high_R1: assert property (@(posedge clk) disable iff (rst)
        !ready_i |=> (a_o && b_o && idx_o));

    assert_fault_safe_R2: assert property (@(posedge clk) disable iff (rst)
        fault_i |=> (a_o && b_o && idx_o));

    assert_index_phase_R7: assert property (@(posedge clk) disable iff (rst)
        (idx_o && !(a_o && b_o)) |-> (!a_o && !b_o));

endmodule

// File: rtl/quad_step_gen.sv
module quad_step_gen
    import qenc_pkg::*;
#(
    parameter int ANGLE_W  = ANG_W,
    parameter int POS_W    = qenc_pkg::POS_W,
    parameter int STEP_GAP = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [ANGLE_W-1:0] angle_i,
    input  logic               angle_vld_i,
    input  logic [2:0]         res_sel_i,
    input  logic               bin_mode_i,
    input  logic               dir_inv_i,
    input  logic [1:0]         hyst_i,
    input  logic               fault_i,
    input  logic               ready_i,
    output logic               out_a,
    output logic               out_b,
    output logic               out_idx
);
    logic [ANGLE_W-1:0] held;
    logic [POS_W-1:0]   target;
    logic [POS_W-1:0]   spr;
    logic [POS_W-1:0]   pos;

    qenc_hyst #(.ANGLE_W(ANGLE_W)) u_hyst (
        .clk     (clk),
        .rst     (rst),
        .ready_i (ready_i),
        .angle_i (angle_i),
        .vld_i   (angle_vld_i),
        .hys_i   (hyst_i),
        .held_o  (held)
    );

    qenc_scale #(.ANGLE_W(ANGLE_W), .POS_W(POS_W)) u_scale (
        .clk      (clk),
        .rst      (rst),
        .held_i   (held),
        .res_i    (res_sel_i),
        .bin_i    (bin_mode_i),
        .target_o (target),
        .spr_o    (spr)
    );

    qenc_stepper #(.POS_W(POS_W), .STEP_GAP(STEP_GAP)) u_step (
        .clk      (clk),
        .rst      (rst),
        .ready_i  (ready_i),
        .target_i (target),
        .spr_i    (spr),
        .pos_o    (pos)
    );

    qenc_outfmt #(.POS_W(POS_W)) u_out (
        .clk     (clk),
        .rst     (rst),
        .ready_i (ready_i),
        .fault_i (fault_i),
        .inv_i   (dir_inv_i),
        .pos_i   (pos),
        .a_o     (out_a),
        .b_o     (out_b),
        .idx_o   (out_idx)
    );

endmodule

// File: tb/quad_step_gen_test.sv
module quad_step_gen_test;
    localparam int GAP = 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [13:0] angle = '0;
    logic        vld = 1'b0;
    logic [2:0]  res_sel = '0;
    logic        bin_mode = 1'b1;
    logic        dir_inv = 1'b0;
    logic [1:0]  hyst = 2'd3;
    logic        fault = 1'b0;
    logic        ready = 1'b0;
    logic        out_a, out_b, out_idx;

    always #4 clk = ~clk;

    quad_step_gen #(.STEP_GAP(GAP)) uut (
        .clk(clk), .rst(rst), .angle_i(angle), .angle_vld_i(vld),
        .res_sel_i(res_sel), .bin_mode_i(bin_mode), .dir_inv_i(dir_inv),
        .hyst_i(hyst), .fault_i(fault), .ready_i(ready),
        .out_a(out_a), .out_b(out_b), .out_idx(out_idx)
    );

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // requirement model state
    int m_held = 0;
    bit m_up = 1;
    int cur_spr = 4096;
    bit cur_inv = 0;
    int cur_hys = 3;

    // output monitor state
    bit mon_on = 0;
    int cnt = 0, net = 0, idx_rises = 0, quiet = 0, prev_ph = 0;
    bit prev_idx = 0;

    function automatic int modp(int x, int m);
        int r;
        r = x % m;
        if (r < 0) r += m;
        return r;
    endfunction

    function automatic int spr_of(int code, bit bin);
        int dec_tab[8] = '{4000, 2000, 1600, 1200, 800, 400, 200, 100};
        if (bin) return (code == 0) ? 4096 : (code == 1) ? 2048 : 1024;
        return dec_tab[code];
    endfunction

    function automatic int tgt_of(int ang, int spr);
        return int'((longint'(ang) * longint'(spr)) >>> 14);
    endfunction

    function automatic int ph_of(bit a, bit b, bit inv);
        bit x, y;
        x = inv ? b : a;
        y = inv ? a : b;
        case ({x, y})
            2'b00: return 0;
            2'b10: return 1;
            2'b11: return 2;
            default: return 3;
        endcase
    endfunction

    function automatic void model_apply(int ang, bit rdy);
        int d, mag;
        bit fwd;
        if (!rdy) begin
            m_held = ang;
            m_up = 1;
            return;
        end
        d = (ang - m_held) & 16383;
        if (d >= 8192) d -= 16384;
        if (d == 0) return;
        fwd = (d > 0);
        mag = fwd ? d : -d;
        if ((fwd == m_up) || (mag > (3 - cur_hys) * 8)) begin
            m_held = ang;
            m_up = fwd;
        end
    endfunction

    task automatic check(bit ok, string req, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // compare the pins with the pattern of position p
    task automatic check_pos(string req, int p);
        int ph, e;
        bit x, y;
        ph = p % 4;
        x = (ph == 1) || (ph == 2);
        y = (ph >= 2);
        e = {(cur_inv ? y : x), (cur_inv ? x : y), (p == 0)};
        check({out_a, out_b, out_idx} == 3'(e), req, "output pattern {a,b,idx}",
              int'({out_a, out_b, out_idx}), e);
    endtask

    always @(negedge clk) begin
        if (mon_on) begin
            int ph, dl;
            ph = ph_of(out_a, out_b, cur_inv);
            dl = modp(ph - prev_ph, 4);
            quiet++;
            if (dl == 2) begin
                errors++;
                $display("FAIL R6 skipped quadrature phase: actual %0d expected %0d", ph, prev_ph);
            end else if (dl != 0) begin
                if (quiet < GAP) begin
                    errors++;
                    $display("FAIL R9 step spacing: actual %0d expected %0d", quiet, GAP);
                end
                quiet = 0;
                if (dl == 1) begin cnt++; net++; end
                else begin cnt--; net--; end
            end
            prev_ph = ph;
            if (out_idx && !prev_idx) idx_rises++;
            if (out_idx && (modp(cnt, cur_spr) != 0 || out_a || out_b)) begin
                errors++;
                $display("FAIL R7 index away from zero: actual %0d expected %0d",
                         modp(cnt, cur_spr), 0);
            end
            prev_idx = out_idx;
        end
    end

    task automatic sync_mon();
        cnt = tgt_of(m_held, cur_spr);
        net = 0;
        idx_rises = 0;
        quiet = GAP;
        prev_ph = ph_of(out_a, out_b, cur_inv);
        prev_idx = out_idx;
        mon_on = 1;
    endtask

    task automatic apply(int ang);
        @(negedge clk);
        angle = 14'(ang);
        vld = 1'b1;
        model_apply(ang, ready);
        @(negedge clk);
        vld = 1'b0;
    endtask

    task automatic setup(int code, bit bin, bit inv, int hys, int ang);
        mon_on = 0;
        @(negedge clk);
        ready = 1'b0;
        res_sel = 3'(code);
        bin_mode = bin;
        dir_inv = inv;
        hyst = 2'(hys);
        cur_spr = spr_of(code, bin);
        cur_inv = inv;
        cur_hys = hys;
        apply(ang);
        repeat (4) @(negedge clk);
        check({out_a, out_b, out_idx} == 3'b111, "R1", "outputs before ready",
              int'({out_a, out_b, out_idx}), 7);
        ready = 1'b1;
        repeat (4) @(negedge clk);
        check_pos("R1", tgt_of(m_held, cur_spr));
        sync_mon();
    endtask

    task automatic sweep(int code, bit bin, bit inv, bit rev, int exp_spr, string req);
        setup(code, bin, inv, 3, 0);
        for (int k = 1; k <= 256; k++) begin
            int ang;
            ang = rev ? ((16384 - 64 * k) & 16383) : ((64 * k) & 16383);
            apply(ang);
            repeat (32) @(negedge clk);
        end
        repeat (40) @(negedge clk);
        check(net == (rev ? -exp_spr : exp_spr), req, "net steps in one turn",
              net, rev ? -exp_spr : exp_spr);
        check(idx_rises == 1, "R7", "index pulses in one turn", idx_rises, 1);
        check(modp(cnt, cur_spr) == 0, "R5", "position after one turn", modp(cnt, cur_spr), 0);
    endtask

    initial begin
        repeat (195000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check({out_a, out_b, out_idx} == 3'b111, "R1", "outputs after reset",
              int'({out_a, out_b, out_idx}), 7);

        // R6: literal phase after a single upward step, both line orders
        setup(0, 1, 0, 3, 0);
        apply(4);
        repeat (6) @(negedge clk);
        check(out_a == 1'b1 && out_b == 1'b0, "R6", "A leads for dir 0 {a,b}",
              int'({out_a, out_b}), 2);
        setup(0, 1, 1, 3, 0);
        apply(4);
        repeat (6) @(negedge clk);
        check(out_a == 1'b0 && out_b == 1'b1, "R6", "B leads for dir 1 {a,b}",
              int'({out_a, out_b}), 1);

        // R3 / R4: full turns at every resolution
        for (int c = 0; c < 8; c++)
            sweep(c, 0, bit'(c & 1), 0, spr_of(c, 0), "R3");
        sweep(0, 1, 0, 0, 4096, "R4");
        sweep(1, 1, 1, 0, 2048, "R4");
        sweep(2, 1, 0, 0, 1024, "R4");
        sweep(5, 1, 0, 0, 1024, "R4");
        sweep(3, 0, 1, 1, 1200, "R3");
        sweep(0, 1, 0, 1, 4096, "R4");

        // R9 / R10: large jumps, then a jump that is shorter downward through 0
        setup(0, 1, 0, 3, 0);
        apply(4000);
        repeat (2100) @(negedge clk);
        check(net == 1000, "R9", "steps replayed for jump", net, 1000);
        check(idx_rises == 0, "R10", "index on upward jump", idx_rises, 0);
        check_pos("R5", 1000);
        apply(16380);
        repeat (2100) @(negedge clk);
        check(net == -1, "R10", "net after downward wrap", net, -1);
        check(idx_rises == 1, "R10", "index on downward wrap", idx_rises, 1);
        check(modp(cnt, 4096) == 4095, "R10", "position after wrap", modp(cnt, 4096), 4095);

        // R8: band of 24 LSBs, then no band
        setup(0, 1, 0, 0, 1000);
        apply(1040);
        repeat (60) @(negedge clk);
        check(modp(cnt, 4096) == 260, "R8", "same direction accepted", modp(cnt, 4096), 260);
        apply(1020);
        repeat (60) @(negedge clk);
        check(modp(cnt, 4096) == 260, "R8", "reversal inside band ignored", modp(cnt, 4096), 260);
        check_pos("R8", 260);
        apply(1010);
        repeat (60) @(negedge clk);
        check(modp(cnt, 4096) == 252, "R8", "reversal beyond band", modp(cnt, 4096), 252);
        apply(1030);
        repeat (60) @(negedge clk);
        check(modp(cnt, 4096) == 252, "R8", "second reversal inside band", modp(cnt, 4096), 252);
        setup(0, 1, 0, 3, 1000);
        apply(1040);
        apply(1036);
        repeat (60) @(negedge clk);
        check(modp(cnt, 4096) == 259, "R8", "no band follows reversal", modp(cnt, 4096), 259);

        // R2: safe state, tracking continues underneath
        setup(0, 1, 0, 3, 2000);
        @(negedge clk);
        mon_on = 0;
        fault = 1'b1;
        repeat (2) @(negedge clk);
        check({out_a, out_b, out_idx} == 3'b111, "R2", "outputs in fault",
              int'({out_a, out_b, out_idx}), 7);
        apply(2400);
        repeat (300) @(negedge clk);
        check({out_a, out_b, out_idx} == 3'b111, "R2", "outputs still in fault",
              int'({out_a, out_b, out_idx}), 7);
        fault = 1'b0;
        repeat (2) @(negedge clk);
        check_pos("R2", 600);
        sync_mon();

        // R5: random jumps under random settings
        for (int s = 0; s < 2; s++) begin
            int code, ang;
            bit bin;
            bin = bit'($urandom % 2);
            code = bin ? int'($urandom % 8) : int'($urandom % 8);
            ang = int'($urandom % 16384);
            setup(code, bin, bit'($urandom % 2), int'($urandom % 4), ang);
            for (int j = 0; j < 10; j++) begin
                ang = (ang + int'($urandom % 3001) - 1500) & 16383;
                apply(ang);
                repeat (800) @(negedge clk);
                check(modp(cnt, cur_spr) == tgt_of(m_held, cur_spr), "R5", "settled position",
                      modp(cnt, cur_spr), tgt_of(m_held, cur_spr));
                check_pos("R5", tgt_of(m_held, cur_spr));
            end
        end

        mon_on = 0;
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule